// File: doc/BRIEF.md
# Prioritized Interrupt Control Unit

This unit sits beside a small processor's instruction sequencer and decides whether an interrupt should be taken. It accepts five hardware request lines. The top line is non-maskable and needs both a rising edge and a still-high level. The second line is caught on its rising edge. The next two are plain high-level requests. The last is the external vectored request. The unit applies a global enable, three per-line masks and a fixed priority. It then reports one pending flag and a numeric code for the winning line.

The sequencer sends decoded strobes for enable-all, disable-all, set-mask and read-mask, together with the accumulator byte. It marks each instruction-fetch boundary and indicates when the core is halted. It acknowledges the winner in the cycle in which it takes it. The unit also owns the serial output bit and places the serial input bit in the status byte. Bus cycles and vector generation belong to the sequencer.

Top module: `irq_ctrl`

## Requirements
- R1: The non-maskable line requests service only when a rising edge has been latched and the line is still high. Neither the masks nor the global enable affect it. Acknowledging it clears its latch, so a line that stays high gives no second request until it falls and rises again.
- R2: A rising edge on the edge line is latched on the next clock. The latch holds after the line falls. It is cleared by acknowledging that line, or by a set-mask with accumulator bit 4 = 1.
- R3: Each of the two level lines requests service only while it is high.
- R4: Priority from highest to lowest is: non-maskable, edge line, level A, level B, external. The winner code on `src_o` is 1, 2, 3, 4 or 5 respectively. It is 0 whenever `pend_o` is low.
- R5: After reset the three masks are all 1 and the global enable is 0. A set-mask loads the masks from accumulator bits 2..0 (bit 2 edge line, bit 1 level A, bit 0 level B) only when bit 3 = 1. Otherwise the masks keep their value.
- R6: After reset `ser_out_o` is 0. A set-mask sets it to accumulator bit 7 on the next cycle only when bit 6 = 1. Otherwise it keeps its value.
- R7: A mask bit of 1 blocks its line even while the global enable is set. The external line is gated only by the global enable.
- R8: Enable-all sets the status enable bit on the next cycle. Maskable requests are still withheld at the first fetch boundary after the strobe. They are allowed from the following boundary, or while halted once that first boundary has passed.
- R9: Disable-all clears the global enable on the next cycle. No maskable request is presented after that.
- R10: Acknowledging any interrupt clears the global enable on the next cycle.
- R11: The status byte is: bit 7 serial in, bit 6 edge latch, bit 5 level A, bit 4 level B, bit 3 enable, bits 2..0 masks. After the non-maskable interrupt is acknowledged, bit 3 shows the enable value from before it. This holds until a read-mask has been done, or until an enable-all or disable-all is executed. After that, bit 3 shows the live value.
- R12: `pend_o` can be high only in a cycle with `fetch_bound_i` or `halted_i` high. While halted it is evaluated on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| nmi_i | input | 1 | Non-maskable request line |
| edge_i | input | 1 | Rising-edge request line |
| lvl_a_i | input | 1 | Level request line A |
| lvl_b_i | input | 1 | Level request line B |
| ext_i | input | 1 | External vectored request line |
| fetch_bound_i | input | 1 | Sequencer is at an instruction-fetch boundary |
| halted_i | input | 1 | Core is halted |
| ei_i | input | 1 | Enable-all strobe |
| di_i | input | 1 | Disable-all strobe |
| sim_i | input | 1 | Set-mask strobe |
| rim_i | input | 1 | Read-mask strobe |
| acc_i | input | 8 | Accumulator byte for set-mask |
| acc_o | output | 8 | Status byte for read-mask |
| ser_in_i | input | 1 | Serial input bit |
| ser_out_o | output | 1 | Serial output bit |
| ack_i | input | 1 | Sequencer takes the current winner |
| pend_o | output | 1 | An interrupt is to be taken now |
| src_o | output | 3 | Winner code |

## Verification
The assertions check on every cycle the effects that follow one clock after a strobe:
- an edge is latched;
- disable-all and acknowledge clear the enable;
- enable-all holds requests back on the next cycle;
- a set-mask without its enable bits leaves the masks and the serial bit unchanged;
- a masked line never wins;
- a live non-maskable request always wins at a boundary.

Only the bench's scenarios can show the behaviours that span several instructions:
- the two-boundary enable delay;
- priority falling through as lines drop;
- the saved enable value returned by the first read after a non-maskable interrupt;
- a halted core being woken only after the enable delay has run out.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int NUM_LINES = 5;
  localparam int NUM_MASK  = 3;
  localparam int ACC_W     = 8;
  localparam int SRC_W     = 3;

  // set-mask byte
  localparam int SET_SER     = 7;
  localparam int SET_SER_EN  = 6;
  localparam int SET_EDGE_CLR = 4;
  localparam int SET_MASK_EN = 3;

  typedef enum logic [SRC_W-1:0] {
    SRC_NONE  = 3'd0,
    SRC_NMI   = 3'd1,
    SRC_EDGE  = 3'd2,
    SRC_LVL_A = 3'd3,
    SRC_LVL_B = 3'd4,
    SRC_EXT   = 3'd5
  } irq_src_e;
endpackage

// File: rtl/irq_edge_latch.sv
module irq_edge_latch #(
  parameter bit NEED_LEVEL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  input  logic clr_i,
  output logic latch_o,
  output logic req_o
);
  logic prev_q, lat_q, rise;

  assign rise = line_i & ~prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      lat_q  <= 1'b0;
    end else begin
      prev_q <= line_i;
      lat_q  <= (lat_q & ~clr_i) | rise; // a fresh edge wins over a clear
    end
  end

  assign latch_o = lat_q;

  generate
    if (NEED_LEVEL) begin : g_edge_and_level
      assign req_o = lat_q & line_i;
    end else begin : g_edge_only
      assign req_o = lat_q;
    end
  endgenerate

  a_r2_rise_latched: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_i && !prev_q) |=> latch_o);
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int N  = 5,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  req_i,
  output logic          valid_o,
  output logic [IW-1:0] idx_o
);
  // index 0 is the highest priority
  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        valid_o = 1'b1;
        idx_o   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/irq_mode_regs.sv
module irq_mode_regs
  import irq_ctrl_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                ei_i,
  input  logic                di_i,
  input  logic                sim_i,
  input  logic                rim_i,
  input  logic                fetch_bound_i,
  input  logic                ack_i,
  input  logic                ack_nmi_i,
  input  logic [ACC_W-1:0]    acc_i,
  output logic                gate_o,
  output logic                ie_stat_o,
  output logic [NUM_MASK-1:0] mask_o,
  output logic                ser_out_o,
  output logic                edge_clr_o
);
  logic                ie_q, hold_q, ser_q, saved_q, use_saved_q;
  logic [NUM_MASK-1:0] mask_q;
  logic                unused_acc;

  assign unused_acc = acc_i[5];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ie_q        <= 1'b0;
      hold_q      <= 1'b0;
      mask_q      <= '1;
      ser_q       <= 1'b0;
      saved_q     <= 1'b0;
      use_saved_q <= 1'b0;
    end else begin
      if (di_i || ack_i) ie_q <= 1'b0;
      else if (ei_i)     ie_q <= 1'b1;

      // enable-all waits for the boundary that ends the next instruction
      if (di_i)               hold_q <= 1'b0;
      else if (ei_i)          hold_q <= 1'b1;
      else if (fetch_bound_i) hold_q <= 1'b0;

      if (sim_i && acc_i[SET_MASK_EN]) mask_q <= acc_i[NUM_MASK-1:0];
      if (sim_i && acc_i[SET_SER_EN])  ser_q  <= acc_i[SET_SER];

      if (ei_i || di_i) use_saved_q <= 1'b0;
      else if (ack_nmi_i) begin
        use_saved_q <= 1'b1;
        saved_q     <= ie_q;
      end else if (rim_i) use_saved_q <= 1'b0;
    end
  end

  assign gate_o     = ie_q & ~hold_q;
  assign ie_stat_o  = use_saved_q ? saved_q : ie_q;
  assign mask_o     = mask_q;
  assign ser_out_o  = ser_q;
  assign edge_clr_o = sim_i & acc_i[SET_EDGE_CLR];

  a_r9_di_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    di_i |=> !ie_q && !gate_o);
  a_r10_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |=> !ie_q);
  a_r8_ei_deferred: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ei_i |=> !gate_o);
  a_r5_mask_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sim_i && !acc_i[SET_MASK_EN]) |=> $stable(mask_o));
  a_r6_ser_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sim_i && !acc_i[SET_SER_EN]) |=> $stable(ser_out_o));
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_ctrl_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             nmi_i,
  input  logic             edge_i,
  input  logic             lvl_a_i,
  input  logic             lvl_b_i,
  input  logic             ext_i,
  input  logic             fetch_bound_i,
  input  logic             halted_i,
  input  logic             ei_i,
  input  logic             di_i,
  input  logic             sim_i,
  input  logic             rim_i,
  input  logic [ACC_W-1:0] acc_i,
  output logic [ACC_W-1:0] acc_o,
  input  logic             ser_in_i,
  output logic             ser_out_o,
  input  logic             ack_i,
  output logic             pend_o,
  output logic [SRC_W-1:0] src_o
);
  localparam int IW = $clog2(NUM_LINES);

  logic                 nmi_req, nmi_lat, edge_lat, edge_req;
  logic                 nmi_clr, edge_clr, edge_clr_sim;
  logic                 gate, ie_stat, win_valid, window;
  logic [NUM_MASK-1:0]  mask;
  logic [NUM_LINES-1:0] req;
  logic [IW-1:0]        win_idx;
  logic                 unused_nmi_lat;

  assign unused_nmi_lat = nmi_lat;

  assign nmi_clr  = ack_i && (src_o == SRC_NMI);
  assign edge_clr = (ack_i && (src_o == SRC_EDGE)) || edge_clr_sim;

  irq_edge_latch #(.NEED_LEVEL(1'b1)) u_nmi_lat (
    .clk_i, .rst_ni, .line_i(nmi_i), .clr_i(nmi_clr),
    .latch_o(nmi_lat), .req_o(nmi_req)
  );

  irq_edge_latch #(.NEED_LEVEL(1'b0)) u_edge_lat (
    .clk_i, .rst_ni, .line_i(edge_i), .clr_i(edge_clr),
    .latch_o(edge_lat), .req_o(edge_req)
  );

  irq_mode_regs u_mode (
    .clk_i, .rst_ni, .ei_i, .di_i, .sim_i, .rim_i, .fetch_bound_i, .ack_i,
    .ack_nmi_i(nmi_clr), .acc_i, .gate_o(gate), .ie_stat_o(ie_stat),
    .mask_o(mask), .ser_out_o, .edge_clr_o(edge_clr_sim)
  );

  assign req[0] = nmi_req;
  assign req[1] = gate & edge_req & ~mask[2];
  assign req[2] = gate & lvl_a_i  & ~mask[1];
  assign req[3] = gate & lvl_b_i  & ~mask[0];
  assign req[4] = gate & ext_i;

  irq_prio_enc #(.N(NUM_LINES), .IW(IW)) u_enc (
    .req_i(req), .valid_o(win_valid), .idx_o(win_idx)
  );

  assign window = fetch_bound_i | halted_i;
  assign pend_o = win_valid & window;
  assign src_o  = pend_o ? SRC_W'(win_idx) + SRC_W'(1) : SRC_NONE;

  assign acc_o = {ser_in_i, edge_lat, lvl_a_i, lvl_b_i, ie_stat, mask};

  a_r7_masked_loses: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_o |-> !((src_o == SRC_EDGE  && mask[2]) ||
                 (src_o == SRC_LVL_A && mask[1]) ||
                 (src_o == SRC_LVL_B && mask[0])));
  a_r1_nmi_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (window && nmi_i && acc_o[6:0] == acc_o[6:0] && nmi_req) |-> (pend_o && src_o == SRC_NMI));
  a_r4_code_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_o |-> (src_o != SRC_NONE && src_o <= SRC_EXT));
endmodule

// File: tb/irq_ctrl_bench.sv
`timescale 1ns/100ps
module irq_ctrl_bench;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic nmi_i = 0, edge_i = 0, lvl_a_i = 0, lvl_b_i = 0, ext_i = 0;
  logic fetch_bound_i = 0, halted_i = 0, ei_i = 0, di_i = 0, sim_i = 0, rim_i = 0;
  logic ack_i = 0, ser_in_i = 0;
  logic [7:0] acc_i = 8'h00;
  logic [7:0] acc_o;
  logic ser_out_o, pend_o;
  logic [2:0] src_o;

  int checks = 0, errors = 0;

  // behavioural reference state
  bit m_ie, m_hold, m_ser, m_saved, m_use_saved;
  bit m_nmi_lat, m_edge_lat, m_nmi_prev, m_edge_prev;
  bit [2:0] m_mask;
  bit m_run = 0;

  always #2.5 clk = ~clk;

  irq_ctrl u_irq_ctrl (
    .clk_i(clk), .rst_ni, .nmi_i, .edge_i, .lvl_a_i, .lvl_b_i, .ext_i,
    .fetch_bound_i, .halted_i, .ei_i, .di_i, .sim_i, .rim_i, .acc_i, .acc_o,
    .ser_in_i, .ser_out_o, .ack_i, .pend_o, .src_o
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int m_code();
    if (m_nmi_lat && nmi_i) return 1;
    if (m_ie && !m_hold) begin
      if (m_edge_lat && !m_mask[2]) return 2;
      if (lvl_a_i && !m_mask[1])    return 3;
      if (lvl_b_i && !m_mask[0])    return 4;
      if (ext_i)                    return 5;
    end
    return 0;
  endfunction

  // compare every cycle, then advance the model
  always @(negedge clk) if (m_run) begin
    int code;
    bit pend;
    code = m_code();
    pend = (fetch_bound_i || halted_i) && code != 0;
    chk("model pend", pend_o, pend);
    chk("model src", src_o, pend ? code : 0);
    chk("model status", acc_o, {ser_in_i, m_edge_lat, lvl_a_i, lvl_b_i,
        (m_use_saved ? m_saved : m_ie), m_mask});
    chk("model ser_out", ser_out_o, m_ser);
    if (ei_i || di_i) m_use_saved = 0;
    else if (ack_i && pend && code == 1) begin m_use_saved = 1; m_saved = m_ie; end
    else if (rim_i) m_use_saved = 0;
    if (di_i) m_hold = 0; else if (ei_i) m_hold = 1; else if (fetch_bound_i) m_hold = 0;
    if (di_i || ack_i) m_ie = 0; else if (ei_i) m_ie = 1;
    if (sim_i && acc_i[3]) m_mask = acc_i[2:0];
    if (sim_i && acc_i[6]) m_ser = acc_i[7];
    m_nmi_lat  = (m_nmi_lat && !(ack_i && pend && code == 1)) || (nmi_i && !m_nmi_prev);
    m_edge_lat = (m_edge_lat && !((ack_i && pend && code == 2) || (sim_i && acc_i[4])))
                 || (edge_i && !m_edge_prev);
    m_nmi_prev  = nmi_i;
    m_edge_prev = edge_i;
  end

  task automatic tick();
    @(posedge clk);
    #0.5;
    ei_i = 0; di_i = 0; sim_i = 0; rim_i = 0; ack_i = 0; fetch_bound_i = 0;
  endtask

  task automatic settle();
    #0.5;
  endtask

  task automatic do_sim(logic [7:0] v);
    sim_i = 1; acc_i = v; tick();
  endtask

  task automatic enable_all();
    ei_i = 1; tick();
    fetch_bound_i = 1; tick();
  endtask

  task automatic run_tests();
    m_mask = 3'b111;
    repeat (3) @(posedge clk);
    #0.5 rst_ni = 1;
    m_run = 1;
    settle();
    chk("R5 reset status", acc_o, 8'h07);
    chk("R6 reset ser_out", ser_out_o, 0);
    chk("R12 reset pend", pend_o, 0);
    tick();

    do_sim(8'h08); settle(); chk("R5 masks loaded", acc_o[2:0], 0);
    do_sim(8'h07); settle(); chk("R5 mask ignored", acc_o[2:0], 0);
    do_sim(8'hC0); settle(); chk("R6 ser set", ser_out_o, 1);
    do_sim(8'h80); settle(); chk("R6 ser ignored", ser_out_o, 1);
    do_sim(8'h40); settle(); chk("R6 ser cleared", ser_out_o, 0);

    ei_i = 1; tick(); settle(); chk("R8 status enable", acc_o[3], 1);
    lvl_a_i = 1; fetch_bound_i = 1; settle();
    chk("R8 first boundary held", pend_o, 0);
    tick();
    fetch_bound_i = 1; settle();
    chk("R8 second boundary", pend_o, 1);
    chk("R4 level A code", src_o, 3);
    fetch_bound_i = 0; settle(); chk("R12 no window", pend_o, 0);
    fetch_bound_i = 1; ack_i = 1; tick(); settle();
    chk("R10 ack clears enable", acc_o[3], 0);
    fetch_bound_i = 1; settle(); chk("R10 no request", pend_o, 0);
    tick();

    lvl_b_i = 1; ext_i = 1; edge_i = 1; tick(); edge_i = 0;
    enable_all();
    fetch_bound_i = 1; settle(); chk("R4 edge code", src_o, 2);
    ack_i = 1; tick();
    enable_all();
    fetch_bound_i = 1; settle(); chk("R4 level A over B", src_o, 3);
    lvl_a_i = 0; settle(); chk("R4 level B code", src_o, 4);
    lvl_b_i = 0; settle(); chk("R4 external code", src_o, 5);
    ext_i = 0; settle(); chk("R3 lines low", pend_o, 0);
    tick();

    do_sim(8'h0F);
    lvl_a_i = 1; fetch_bound_i = 1; settle(); chk("R7 masked line", pend_o, 0);
    ext_i = 1; settle(); chk("R7 external unmasked", src_o, 5);
    ext_i = 0; lvl_a_i = 0; tick();

    edge_i = 1; tick(); edge_i = 0; tick(); settle();
    chk("R2 latched", acc_o[6], 1);
    tick(); chk("R2 held", acc_o[6], 1);
    do_sim(8'h10); settle(); chk("R2 cleared by set-mask", acc_o[6], 0);

    nmi_i = 1; tick();
    fetch_bound_i = 1; settle();
    chk("R1 nmi through masks", src_o, 1);
    ack_i = 1; tick(); settle();
    chk("R11 saved enable", acc_o[3], 1);
    rim_i = 1; tick(); settle();
    chk("R11 live enable", acc_o[3], 0);
    fetch_bound_i = 1; settle(); chk("R1 no retrigger", pend_o, 0);
    tick();
    nmi_i = 0; tick();
    di_i = 1; tick(); settle(); chk("R9 status after disable", acc_o[3], 0);
    nmi_i = 1; tick();
    fetch_bound_i = 1; settle(); chk("R1 nmi while disabled", src_o, 1);
    ack_i = 1; tick();
    ei_i = 1; tick(); settle(); chk("R11 enable drops saved", acc_o[3], 1);
    nmi_i = 0;
    fetch_bound_i = 1; tick();
    do_sim(8'h08);
    lvl_b_i = 1; fetch_bound_i = 1; settle(); chk("R3 level B", src_o, 4);
    di_i = 1; tick();
    fetch_bound_i = 1; settle(); chk("R9 disabled", pend_o, 0);
    tick();

    ei_i = 1; tick();
    halted_i = 1; settle(); chk("R12 halted during hold", pend_o, 0);
    halted_i = 0; fetch_bound_i = 1; tick();
    halted_i = 1; settle(); chk("R12 halted wake", pend_o, 1);
    chk("R12 halted code", src_o, 4);
    ack_i = 1; tick();
    halted_i = 0; lvl_b_i = 0; tick(); tick();
  endtask

  initial begin
    fork
      run_tests();
      begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule